// File: doc/BRIEF.md
# Dual-Channel Converter Serial Register Front End

This block is the digital side of a two-channel 12-bit current-output converter. A host talks to it over a three-wire serial port made of a frame strobe, a serial clock and a data line, and can read data back on a fourth line. Each frame carries a 16-bit word. The word goes in most significant bit first. Its upper four bits are an operation code and its lower twelve bits are a converter code. Each channel holds two 12-bit registers. The first is a staging register that serial writes fill. The second is the output register that drives the analog ladder.

The staging registers move to the output registers in one of three ways: a synchronous active-low load pin, an operation that updates both channels, or a write that also updates. An active-low clear pin forces both output registers to zero. By default the serial port is in chained mode. In that mode the shift register's overflow leaves on the data-out line so that several devices can be cascaded, and a word takes effect when the frame strobe rises. Once chaining is switched off, a word takes effect on its sixteenth capture edge. A read operation makes the next frame carry the selected output register out on the data-out line. A mode command chooses whether data is captured on the falling or the rising serial clock edge.

The serial pins are sampled with the system clock, so the serial clock must run well below that clock rate.

Top module: `dualdac_serial_front`

## Requirements
- R1: After synchronous reset both output codes are zero, the data-out line is low, chained mode is active and capture happens on the falling serial clock edge.
- R2: A word is sent MSB first with the strobe low. Bits 15..12 are the operation code and bits 11..0 are the code value.
- R3: Operation 0x5 (or 0x6) writes the channel A (or B) staging register and leaves both outputs alone. A low load pin, sampled on the clock, copies both staging registers to the outputs.
- R4: Operation 0x1 (or 0x2) writes channel A (or B) staging and output together, whatever the load pin level. Operation 0x8 does the same for both channels.
- R5: Operation 0x7 copies both staging registers to their outputs.
- R6: With chaining off, a word acts in the clock after its 16th capture edge. Capture edges after the 16th in the same frame are ignored. A frame that ends before 16 bits changes nothing.
- R7: In chained mode a word acts in the clock after the strobe rises, using the last 16 bits captured. Data-out presents the shift register's MSB before each capture, so a bit reappears 16 captures after it went in.
- R8: Operation 0x9 toggles chained mode. The toggle does not cause the same frame to be executed a second time at its strobe edge.
- R9: Operation 0x3 (or 0x4) makes the following frame send 0000 followed by the channel A (or B) output code on data-out, MSB first. Outside chained mode, data-out is otherwise low.
- R10: Operation 0xA selects rising-edge capture and 0xB selects falling-edge capture. Data-out then changes on the opposite edge.
- R11: While the clear pin is low, both outputs go to zero in the next clock. The staging registers keep their values.
- R12: Operation codes 0x0 and 0xC to 0xF change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all serial and control pins |
| rst | input | 1 | Synchronous active-high reset |
| sync_n | input | 1 | Frame strobe, low during a frame |
| sclk | input | 1 | Serial clock |
| sdin | input | 1 | Serial data in |
| ldac_n | input | 1 | Active-low load of staging registers into outputs |
| clr_n | input | 1 | Active-low clear of output registers |
| sdo | output | 1 | Serial data out (chain overflow or readback) |
| code_a | output | 12 | Channel A output register |
| code_b | output | 12 | Channel B output register |

## Verification
The hardest situations to reach are those where a word changes the serial port's own rules partway through a frame. One is the chaining toggle sent while chaining is off: it acts on the 16th edge, and the strobe edge at the end of the same frame must not run the word again. Another is a clock-edge switch followed by frames on the new edge. The stimulus drives each of these in sequence. It also sends a 32-bit chained frame, so that data-out must repeat the earlier contents bit for bit, and a readback word followed by two more frames, so that data-out must carry the code in the first of them and stay silent in the second.

// File: rtl/dsf_pkg.sv
package dsf_pkg;
    localparam int CODE_W = 12;
    localparam int CMD_W  = 4;
    localparam int WORD_W = CMD_W + CODE_W;
    localparam int CNT_W  = $clog2(WORD_W + 1);
    localparam int N_CH   = 2;

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [CMD_W-1:0] {
        OP_NOP       = 4'h0,
        OP_LDUPD_A   = 4'h1,
        OP_LDUPD_B   = 4'h2,
        OP_READ_A    = 4'h3,
        OP_READ_B    = 4'h4,
        OP_WRIN_A    = 4'h5,
        OP_WRIN_B    = 4'h6,
        OP_UPD_ALL   = 4'h7,
        OP_LDUPD_ALL = 4'h8,
        OP_CHAIN_TGL = 4'h9,
        OP_EDGE_RISE = 4'hA,
        OP_EDGE_FALL = 4'hB
    } op_e;

    typedef struct packed {
        logic [CMD_W-1:0] op;
        code_t            data;
    } word_t;

    // Decoded effect of one executed word.
    typedef struct packed {
        logic [N_CH-1:0] wr_in;     // write staging register
        logic [N_CH-1:0] ld_dac;    // write output register with word data
        logic [N_CH-1:0] xfer;      // copy staging into output
        logic [N_CH-1:0] rd_sel;    // readback source
        logic            chain_tgl;
        logic            edge_set;
        logic            edge_rise;
    } act_t;

    function automatic act_t decode_word(input word_t w);
        act_t a;
        a = '0;
        case (w.op)
            OP_LDUPD_A:   begin a.wr_in[0] = 1'b1; a.ld_dac[0] = 1'b1; end
            OP_LDUPD_B:   begin a.wr_in[1] = 1'b1; a.ld_dac[1] = 1'b1; end
            OP_READ_A:    a.rd_sel[0] = 1'b1;
            OP_READ_B:    a.rd_sel[1] = 1'b1;
            OP_WRIN_A:    a.wr_in[0] = 1'b1;
            OP_WRIN_B:    a.wr_in[1] = 1'b1;
            OP_UPD_ALL:   a.xfer = '1;
            OP_LDUPD_ALL: begin a.wr_in = '1; a.ld_dac = '1; end
            OP_CHAIN_TGL: a.chain_tgl = 1'b1;
            OP_EDGE_RISE: begin a.edge_set = 1'b1; a.edge_rise = 1'b1; end
            OP_EDGE_FALL: a.edge_set = 1'b1;
            default:      a = '0;
        endcase
        return a;
    endfunction
endpackage

// File: rtl/dsf_edge_det.sv
module dsf_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic sync_n,
    input  logic rise_mode,
    output logic cap_edge,
    output logic launch_edge,
    output logic sync_rise,
    output logic sync_fall
);
    logic sclk_q;
    logic sync_q;
    logic sclk_up;
    logic sclk_dn;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b1;
            sync_q <= 1'b1;
        end else begin
            sclk_q <= sclk;
            sync_q <= sync_n;
        end
    end

    assign sclk_up     = sclk & ~sclk_q;
    assign sclk_dn     = ~sclk & sclk_q;
    assign cap_edge    = rise_mode ? sclk_up : sclk_dn;
    assign launch_edge = rise_mode ? sclk_dn : sclk_up;
    assign sync_rise   = sync_n & ~sync_q;
    assign sync_fall   = ~sync_n & sync_q;
endmodule

// File: rtl/dsf_frame_rx.sv
module dsf_frame_rx
    import dsf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sdin,
    input  logic              sync_n,
    input  logic              cap_edge,
    input  logic              launch_edge,
    input  logic              sync_rise,
    input  logic              sync_fall,
    input  logic              chain_mode,
    input  logic              ld_rb,
    input  logic [WORD_W-1:0] rb_word,
    output logic              exec_vld,
    output logic [WORD_W-1:0] exec_word,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              sdo
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] shifted;
    logic [CNT_W-1:0]  cnt;
    logic              done;
    logic              sdo_q;
    logic              rb_req;
    logic              rb_active;
    logic              shift_en;
    logic              exec_sa;
    logic              exec_dc;

    assign shift_en = cap_edge && !sync_n && (chain_mode || cnt < CNT_FULL);
    assign shifted  = {shreg[WORD_W-2:0], sdin};
    assign exec_sa  = shift_en && !chain_mode && (cnt == CNT_LAST);
    assign exec_dc  = sync_rise && chain_mode && !done && (cnt == CNT_FULL);

    assign exec_vld  = exec_sa || exec_dc;
    assign exec_word = exec_sa ? shifted : shreg;
    assign bit_cnt   = cnt;
    assign sdo       = sdo_q & (chain_mode | rb_active);

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            cnt       <= '0;
            done      <= 1'b0;
            sdo_q     <= 1'b0;
            rb_req    <= 1'b0;
            rb_active <= 1'b0;
        end else begin
            if (sync_fall) begin
                cnt       <= '0;
                done      <= 1'b0;
                sdo_q     <= shreg[WORD_W-1];
                rb_active <= rb_req;
                rb_req    <= 1'b0;
            end
            if (sync_rise) begin
                rb_active <= 1'b0;
            end
            if (shift_en) begin
                shreg <= shifted;
                if (cnt != CNT_FULL) begin
                    cnt <= cnt + 1'b1;
                end
            end
            if (exec_sa) begin
                done <= 1'b1;
            end
            if (launch_edge && !sync_n) begin
                sdo_q <= shreg[WORD_W-1];
            end
            if (ld_rb) begin
                shreg  <= rb_word;
                rb_req <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dsf_chan_regs.sv
module dsf_chan_regs
    import dsf_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr_n,
    input  logic                         ldac_n,
    input  act_t                         act,
    input  code_t                        data,
    output logic [N_CH-1:0][CODE_W-1:0]  dac_o,
    output logic [N_CH-1:0][CODE_W-1:0]  in_o,
    output logic [WORD_W-1:0]            rb_word,
    output logic                         chain_mode,
    output logic                         rise_mode
);
    logic chain_dis;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        code_t in_r;
        code_t dac_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                in_r  <= '0;
                dac_r <= '0;
            end else begin
                if (!ldac_n) dac_r <= in_r;
                if (act.xfer[c]) dac_r <= in_r;
                if (act.ld_dac[c]) dac_r <= data;
                if (act.wr_in[c]) in_r <= data;
                if (!clr_n) dac_r <= '0;
            end
        end

        assign dac_o[c] = dac_r;
        assign in_o[c]  = in_r;
    end

    always_comb begin
        rb_word = '0;
        for (int c = 0; c < N_CH; c++) begin
            if (act.rd_sel[c]) begin
                rb_word = rb_word | {{CMD_W{1'b0}}, dac_o[c]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_dis <= 1'b0;
            rise_mode <= 1'b0;
        end else begin
            if (act.chain_tgl) chain_dis <= ~chain_dis;
            if (act.edge_set)  rise_mode <= act.edge_rise;
        end
    end

    assign chain_mode = ~chain_dis;
endmodule

// File: rtl/dualdac_serial_front.sv
module dualdac_serial_front
    import dsf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_n,
    input  logic              sclk,
    input  logic              sdin,
    input  logic              ldac_n,
    input  logic              clr_n,
    output logic              sdo,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b
);
    logic                        cap_edge;
    logic                        launch_edge;
    logic                        sync_rise;
    logic                        sync_fall;
    logic                        chain_mode;
    logic                        rise_mode;
    logic                        exec_vld;
    logic [WORD_W-1:0]           exec_word;
    logic [CNT_W-1:0]            bit_cnt;
    logic [WORD_W-1:0]           rb_word;
    logic [N_CH-1:0][CODE_W-1:0] dac_all;
    logic [N_CH-1:0][CODE_W-1:0] in_all;
    act_t                        act;
    word_t                       word_s;

    assign word_s = word_t'(exec_word);
    assign act    = exec_vld ? decode_word(word_s) : '0;

    dsf_edge_det u_edge (
        .clk         (clk),
        .rst         (rst),
        .sclk        (sclk),
        .sync_n      (sync_n),
        .rise_mode   (rise_mode),
        .cap_edge    (cap_edge),
        .launch_edge (launch_edge),
        .sync_rise   (sync_rise),
        .sync_fall   (sync_fall)
    );

    dsf_frame_rx u_rx (
        .clk         (clk),
        .rst         (rst),
        .sdin        (sdin),
        .sync_n      (sync_n),
        .cap_edge    (cap_edge),
        .launch_edge (launch_edge),
        .sync_rise   (sync_rise),
        .sync_fall   (sync_fall),
        .chain_mode  (chain_mode),
        .ld_rb       (|act.rd_sel),
        .rb_word     (rb_word),
        .exec_vld    (exec_vld),
        .exec_word   (exec_word),
        .bit_cnt     (bit_cnt),
        .sdo         (sdo)
    );

    dsf_chan_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .clr_n      (clr_n),
        .ldac_n     (ldac_n),
        .act        (act),
        .data       (word_s.data),
        .dac_o      (dac_all),
        .in_o       (in_all),
        .rb_word    (rb_word),
        .chain_mode (chain_mode),
        .rise_mode  (rise_mode)
    );

    assign code_a = dac_all[0];
    assign code_b = dac_all[1];
endmodule

// File: rtl/dsf_checker.sv
module dsf_checker
    import dsf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              clr_n,
    input logic              ldac_n,
    input logic              sdo,
    input logic              exec_vld,
    input logic              cap_edge,
    input logic              sync_rise,
    input logic              chain_mode,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic [CODE_W-1:0] in_a,
    input logic [CODE_W-1:0] in_b,
    input logic [CODE_W-1:0] code_a,
    input logic [CODE_W-1:0] code_b
);
    assert_clear_zero_R11: assert property (@(posedge clk) disable iff (rst)
        !clr_n |=> (code_a == '0 && code_b == '0));

    assert_load_pin_copy_R3: assert property (@(posedge clk) disable iff (rst)
        (clr_n && !ldac_n && !exec_vld) |=> (code_a == $past(in_a) && code_b == $past(in_b)));

    assert_hold_without_cause_R6: assert property (@(posedge clk) disable iff (rst)
        (clr_n && ldac_n && !exec_vld) |=> ($stable(code_a) && $stable(code_b)));

    assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= CNT_W'(WORD_W));

    assert_exec_point_R7: assert property (@(posedge clk) disable iff (rst)
        exec_vld |-> (cap_edge || sync_rise));

    assert_sdo_quiet_after_frame_R9: assert property (@(posedge clk) disable iff (rst)
        (sync_rise && !chain_mode) |=> !sdo);
endmodule

bind dualdac_serial_front dsf_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .clr_n      (clr_n),
    .ldac_n     (ldac_n),
    .sdo        (sdo),
    .exec_vld   (exec_vld),
    .cap_edge   (cap_edge),
    .sync_rise  (sync_rise),
    .chain_mode (chain_mode),
    .bit_cnt    (bit_cnt),
    .in_a       (in_all[0]),
    .in_b       (in_all[1]),
    .code_a     (code_a),
    .code_b     (code_b)
);

// File: tb/dualdac_serial_front_tb_top.sv
module dualdac_serial_front_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync_n = 1'b1;
    logic sclk = 1'b1;
    logic sdin = 1'b0;
    logic ldac_n = 1'b1;
    logic clr_n = 1'b1;
    logic sdo;
    logic [11:0] code_a;
    logic [11:0] code_b;

    int n_chk = 0;
    int n_fail = 0;
    string cur_req = "R1";

    // reference model state
    logic [11:0] exp_a = '0, exp_b = '0, m_in_a = '0, m_in_b = '0;
    logic [15:0] m_sh = '0;
    int m_cnt = 0;
    bit m_done = 0, m_chain_dis = 0, m_rise = 0, m_rb_req = 0, m_rb_act = 0;

    always #2 clk = ~clk;

    dualdac_serial_front dut_i (
        .clk(clk), .rst(rst), .sync_n(sync_n), .sclk(sclk), .sdin(sdin),
        .ldac_n(ldac_n), .clr_n(clr_n), .sdo(sdo), .code_a(code_a), .code_b(code_b)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h", cur_req, what, act, exp);
        end
    endtask

    // compare outputs with the model on every clock
    always @(negedge clk) begin
        if (!rst) begin
            chk({4'h0, code_a}, {4'h0, exp_a}, "code_a");
            chk({4'h0, code_b}, {4'h0, exp_b}, "code_b");
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic void m_exec(input logic [15:0] w);
        case (w[15:12])
            4'h1: begin m_in_a = w[11:0]; exp_a = w[11:0]; end
            4'h2: begin m_in_b = w[11:0]; exp_b = w[11:0]; end
            4'h3: begin m_sh = {4'h0, exp_a}; m_rb_req = 1; end
            4'h4: begin m_sh = {4'h0, exp_b}; m_rb_req = 1; end
            4'h5: m_in_a = w[11:0];
            4'h6: m_in_b = w[11:0];
            4'h7: begin exp_a = m_in_a; exp_b = m_in_b; end
            4'h8: begin m_in_a = w[11:0]; m_in_b = w[11:0]; exp_a = w[11:0]; exp_b = w[11:0]; end
            4'h9: m_chain_dis = !m_chain_dis;
            4'hA: m_rise = 1;
            4'hB: m_rise = 0;
            default: ;
        endcase
    endfunction

    function automatic void m_capture(input logic b);
        if (!m_chain_dis || m_cnt < 16) begin
            m_sh = {m_sh[14:0], b};
            if (m_cnt < 16) m_cnt++;
            if (m_chain_dis && m_cnt == 16) begin
                m_done = 1;
                m_exec(m_sh);
            end
        end
    endfunction

    task automatic send(input logic [31:0] bits, input int n);
        logic cl;
        logic exp_sdo;
        cl = m_rise ? 1'b1 : 1'b0;
        sclk = ~cl; step();
        sync_n = 0; step();
        m_cnt = 0; m_done = 0; m_rb_act = m_rb_req; m_rb_req = 0;
        for (int i = n - 1; i >= 0; i--) begin
            sdin = bits[i];
            exp_sdo = (!m_chain_dis || m_rb_act) ? m_sh[15] : 1'b0;
            chk({15'h0, sdo}, {15'h0, exp_sdo}, "sdo");
            sclk = cl; step();
            m_capture(bits[i]);
            sclk = ~cl; step();
        end
        sync_n = 1; step();
        if (!m_chain_dis && !m_done && m_cnt == 16) m_exec(m_sh);
        m_rb_act = 0;
        step();
    endtask

    task automatic pulse_ldac();
        ldac_n = 0; step();
        exp_a = m_in_a; exp_b = m_in_b;
        ldac_n = 1; step();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog act=hung exp=finished");
        finish_run();
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst = 0;
        step();
        // R1: reset state
        cur_req = "R1";
        chk({4'h0, code_a}, 16'h0, "reset code_a");
        chk({4'h0, code_b}, 16'h0, "reset code_b");
        chk({15'h0, sdo}, 16'h0, "reset sdo");

        // R7/R2: chained default, acts on strobe rise
        cur_req = "R7";
        send(32'h1ABC, 16);
        chk({4'h0, code_a}, 16'h0ABC, "chained load A");
        // R7: 32-bit chained frame, earlier word reappears on sdo
        send({16'h5123, 16'h6456}, 32);
        cur_req = "R2";
        chk({4'h0, code_b}, 16'h0000, "only last word executed");

        // R8: turn chaining off
        cur_req = "R8";
        send(32'h9000, 16);
        send(32'h0000, 16);

        // R3: staging write then load pin
        cur_req = "R3";
        send(32'h5321, 16);
        chk({4'h0, code_a}, 16'h0ABC, "staging only");
        pulse_ldac();
        chk({4'h0, code_a}, 16'h0321, "ldac A");
        chk({4'h0, code_b}, 16'h0456, "ldac B");

        // R6: partial frame discarded, extra edges ignored
        cur_req = "R6";
        send(32'h17F, 10);
        pulse_ldac();
        chk({4'h0, code_a}, 16'h0321, "partial frame ignored");
        send({16'h2777, 4'hF}, 20);
        chk({4'h0, code_b}, 16'h0777, "extra bits ignored");

        // R4: load-and-update, single and both
        cur_req = "R4";
        send(32'h1111, 16);
        chk({4'h0, code_a}, 16'h0111, "load-update A");
        send(32'h8555, 16);
        chk({4'h0, code_b}, 16'h0555, "load-update both");

        // R5: update both from staging
        cur_req = "R5";
        send(32'h5AAA, 16);
        send(32'h6BBB, 16);
        send(32'h7000, 16);
        chk({4'h0, code_a}, 16'h0AAA, "update all A");
        chk({4'h0, code_b}, 16'h0BBB, "update all B");

        // R9: readback of B, then quiet frame
        cur_req = "R9";
        send(32'h4000, 16);
        send(32'h0000, 16);
        send(32'h0000, 16);
        chk({15'h0, sdo}, 16'h0, "sdo idle");

        // R10: rising-edge capture
        cur_req = "R10";
        send(32'hA000, 16);
        send(32'h2777, 16);
        chk({4'h0, code_b}, 16'h0777, "rising capture");
        send(32'h3000, 16);
        send(32'h0000, 16);
        send(32'hB000, 16);
        send(32'h1123, 16);
        chk({4'h0, code_a}, 16'h0123, "back to falling");

        // R11: clear pin
        cur_req = "R11";
        clr_n = 0; step();
        exp_a = '0; exp_b = '0;
        step();
        clr_n = 1; step();
        pulse_ldac();
        chk({4'h0, code_a}, 16'h0123, "staging kept A");
        chk({4'h0, code_b}, 16'h0777, "staging kept B");

        // R12: no-op codes
        cur_req = "R12";
        send(32'hC123, 16);
        send(32'hF456, 16);
        send(32'h0789, 16);
        pulse_ldac();
        chk({4'h0, code_a}, 16'h0123, "no-op A");

        // R8: toggle back to chaining while chaining off; single execution
        cur_req = "R8";
        send(32'h9000, 16);
        send(32'h1222, 16);
        chk({4'h0, code_a}, 16'h0222, "chained again");
        send({16'h2999, 16'h0000}, 32);
        chk({4'h0, code_b}, 16'h0777, "chained last word only");

        finish_run();
    end
endmodule